// File: doc/BRIEF.md
# SCSI DMA Transfer-Length Controller

This block runs one data-transfer phase of a SCSI host controller's DMA engine. On a start strobe it takes the 16-bit programmed byte count and works out how many bytes the phase will move. A count of zero stands for the largest transfer, 65536 bytes. In the command phase the length is limited to 32 bytes. In a data phase it is limited to the magnitude of the signed phase residual. The sign of the residual gives the direction: negative means bytes flow toward the device.

The device side reports how many bytes it has ready in its buffer, and the block moves data in chunks between that buffer and the memory-side DMA port. Each chunk is issued as a one-cycle request that carries a length and a direction. After each chunk the block updates the remaining length, the buffer level and the residual. When the transfer ends it posts completion to its status, interrupt and sequence registers, zeroes its count register and raises the interrupt.

Completion either comes at once or waits for the next device event. Which one applies depends on the direction, on whether the device buffer was drained, and on the residual. A command-done event from the device ends any transfer and places the status phase at 3. An abort drops back to idle and posts nothing.

Top module: `scsi_dma_xfer_ctrl`

## Requirements
- R1: After reset, status_o, intr_o, seq_o, count_o, rem_o, residual_o and buf_len_o are zero, and irq_o, busy_o, done_o and chunk_req_o are low.
- R2: At an accepted start, rem_o becomes the effective length. The programmed count L is used as is, except that a count of 0 means 65536. In a data phase the effective length is min(L, |residual_i|).
- R3: In the command phase (cmd_phase_i=1), the effective length is min(L, 32). One cycle after the start, one chunk of that length is requested toward the device (chunk_to_dev_o=1), unless the length is 0. In the same cycle the transfer completes and residual_o becomes 0.
- R4: An accepted start sets the following:
  - status_o bit 4 (terminal count) and bit 7 (interrupt) to 0;
  - status_o[2:0] to the phase: 2 for command, 0 toward the device, 1 from the device;
  - intr_o to 0 and seq_o to 4;
  - count_o to count_i;
  - busy_o high.
- R5: In a data phase, the cycle after the start, and the cycle after a buffer event that leaves remaining length, issue a chunk of min(remaining, buffer). Both the remaining length and the buffer level drop by the chunk. The residual rises by the chunk toward the device and falls by it from the device. A chunk of zero length is not requested.
- R6: If the device buffer is empty when a data chunk would be issued, no chunk is requested and the block stays busy until a buffer event (dev_buf_i with dev_len_i) arrives.
- R7: If a chunk leaves bytes in the device buffer, the transfer completes in the same cycle as that chunk.
- R8: If a chunk drains the buffer, the transfer completes at once only when the direction is from the device, the remaining length is 0 and the residual is still positive. Otherwise the block waits.
- R9: While waiting with zero remaining length, a buffer event completes the transfer if the residual is zero or negative.
- R10: Completion pulses done_o for one cycle. It sets status_o bits 4 and 7 and irq_o, writes 0x10 (bus service) to intr_o, and zeroes seq_o and count_o.
- R11: dev_done_i zeroes the residual, the remaining length and the buffer level, and sets status_o[2:0] to 3. It then completes as in R10 and returns to idle.
- R12: A start strobe that arrives while busy_o is high has no effect on rem_o, count_o or status_o.
- R13: abort_i returns the block to idle (busy_o low) with no done_o pulse and no change to status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transfer phase |
| cmd_phase_i | input | 1 | Start is for the command phase |
| count_i | input | CNT_W | Programmed byte count (0 means 65536) |
| residual_i | input | RES_W | Signed phase residual, negative toward device |
| abort_i | input | 1 | Return to idle without completion |
| dev_buf_i | input | 1 | Device buffer event |
| dev_len_i | input | BUF_W | Bytes ready in the device buffer at the event |
| dev_done_i | input | 1 | Device signals command done |
| chunk_req_o | output | 1 | One-cycle chunk request |
| chunk_len_o | output | CNT_W+1 | Chunk length |
| chunk_to_dev_o | output | 1 | Chunk direction, 1 = memory to device |
| done_o | output | 1 | Completion strobe |
| busy_o | output | 1 | Transfer active |
| rem_o | output | CNT_W+1 | Remaining transfer length |
| residual_o | output | RES_W | Current signed residual |
| buf_len_o | output | BUF_W | Device buffer level |
| status_o | output | 8 | Status: [2:0] phase, [4] terminal count, [7] interrupt |
| intr_o | output | 8 | Interrupt cause register |
| seq_o | output | 3 | Sequence step |
| count_o | output | CNT_W | Count register |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench uses the default parameters: a 16-bit count, a 24-bit signed residual, a 17-bit buffer level and a command limit of 32. With these values a zero count can really produce a single 65536-byte chunk, since the buffer is wide enough to hold more than that. The 24-bit residual lets the bench clamp against residuals both above and below the programmed count. Random rounds mix buffer levels below, equal to and above the effective length, in both directions. They cover zero-length residuals and the choice between immediate and deferred completion. Directed cases walk through multi-chunk waits, the command-done path, starts while busy, and abort.

// File: rtl/scsi_xfer_pkg.sv
package scsi_xfer_pkg;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_XFER = 2'd1,
    XS_WAIT = 2'd2,
    XS_CMD  = 2'd3
  } xfer_state_e;

  localparam int unsigned STAT_TC_BIT  = 4;
  localparam int unsigned STAT_INT_BIT = 7;

  localparam logic [7:0] INTR_BUS_SVC = 8'h10;

  localparam logic [2:0] PH_DATA_OUT = 3'd0;
  localparam logic [2:0] PH_DATA_IN  = 3'd1;
  localparam logic [2:0] PH_COMMAND  = 3'd2;
  localparam logic [2:0] PH_STATUS   = 3'd3;

  localparam logic [2:0] SEQ_ACTIVE  = 3'd4;

endpackage

// File: rtl/xfer_len_calc.sv
module xfer_len_calc #(
  parameter int CNT_W   = 16,
  parameter int RES_W   = 24,
  parameter int CMD_MAX = 32
) (
  input  logic [CNT_W-1:0]        count_i,
  input  logic signed [RES_W-1:0] residual_i,
  input  logic                    cmd_phase_i,
  output logic [CNT_W:0]          len_o
);
  localparam int LW  = CNT_W + 1;
  localparam int AW  = RES_W + 1;
  localparam int MW  = (AW > LW) ? AW : LW;
  localparam logic [LW-1:0] CMD_LIM = LW'(CMD_MAX);

  logic [LW-1:0] full_len;
  logic [AW-1:0] res_ext;
  logic [AW-1:0] res_mag;
  logic [MW-1:0] full_w;
  logic [MW-1:0] mag_w;

  always_comb begin
    full_len = (count_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count_i};
    res_ext  = {residual_i[RES_W-1], residual_i};
    res_mag  = res_ext[AW-1] ? (~res_ext + 1'b1) : res_ext;
    full_w   = MW'(full_len);
    mag_w    = MW'(res_mag);
    if (cmd_phase_i) begin
      len_o = (full_len > CMD_LIM) ? CMD_LIM : full_len;
    end else if (mag_w < full_w) begin
      len_o = res_mag[LW-1:0];
    end else begin
      len_o = full_len;
    end
  end

endmodule

// File: rtl/xfer_chunk_step.sv
module xfer_chunk_step #(
  parameter int LEN_W = 17,
  parameter int BUF_W = 17,
  parameter int RES_W = 24
) (
  input  logic [LEN_W-1:0]        rem_i,
  input  logic [BUF_W-1:0]        buf_i,
  input  logic signed [RES_W-1:0] res_i,
  input  logic                    to_dev_i,
  output logic [LEN_W-1:0]        chunk_o,
  output logic [LEN_W-1:0]        rem_nx_o,
  output logic [BUF_W-1:0]        buf_nx_o,
  output logic signed [RES_W-1:0] res_nx_o,
  output logic                    finish_o
);
  localparam int MW = (LEN_W > BUF_W) ? LEN_W : BUF_W;

  logic [MW-1:0]           rem_w;
  logic [MW-1:0]           buf_w;
  logic [MW-1:0]           chunk_w;
  logic signed [RES_W-1:0] chunk_s;
  logic                    res_pos;

  always_comb begin
    rem_w    = MW'(rem_i);
    buf_w    = MW'(buf_i);
    chunk_w  = (rem_w <= buf_w) ? rem_w : buf_w;
    chunk_o  = chunk_w[LEN_W-1:0];
    rem_nx_o = rem_i - chunk_o;
    buf_nx_o = BUF_W'(buf_w - chunk_w);
    chunk_s  = signed'(RES_W'(chunk_w));
    res_nx_o = to_dev_i ? (res_i + chunk_s) : (res_i - chunk_s);
    res_pos  = !res_nx_o[RES_W-1] && (res_nx_o != '0);
    finish_o = (buf_nx_o != '0) ||
               (!to_dev_i && (rem_nx_o == '0) && res_pos);
  end

endmodule

// File: rtl/xfer_status_regs.sv
module xfer_status_regs
  import scsi_xfer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_i,
  input  logic [2:0]       start_phase_i,
  input  logic [CNT_W-1:0] start_count_i,
  input  logic             ev_finish_i,
  input  logic             ev_devdone_i,
  output logic [7:0]       status_o,
  output logic [7:0]       intr_o,
  output logic [2:0]       seq_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  logic [7:0]       status_q, status_d;
  logic [7:0]       intr_q, intr_d;
  logic [2:0]       seq_q, seq_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             upd_en;

  always_comb begin
    status_d = status_q;
    intr_d   = intr_q;
    seq_d    = seq_q;
    count_d  = count_q;
    if (ev_devdone_i || ev_finish_i) begin
      if (ev_devdone_i) begin
        status_d      = '0;
        status_d[2:0] = PH_STATUS;
      end
      status_d[STAT_TC_BIT]  = 1'b1;
      status_d[STAT_INT_BIT] = 1'b1;
      intr_d  = INTR_BUS_SVC;
      seq_d   = '0;
      count_d = '0;
    end else if (ev_start_i) begin
      status_d[STAT_TC_BIT]  = 1'b0;
      status_d[STAT_INT_BIT] = 1'b0;
      status_d[2:0]          = start_phase_i;
      intr_d  = '0;
      seq_d   = SEQ_ACTIVE;
      count_d = start_count_i;
    end
  end

  assign upd_en = ev_start_i | ev_finish_i | ev_devdone_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      intr_q   <= '0;
      seq_q    <= '0;
      count_q  <= '0;
    end else if (upd_en) begin
      status_q <= status_d;
      intr_q   <= intr_d;
      seq_q    <= seq_d;
      count_q  <= count_d;
    end
  end

  assign status_o = status_q;
  assign intr_o   = intr_q;
  assign seq_o    = seq_q;
  assign count_o  = count_q;
  assign irq_o    = status_q[STAT_INT_BIT];

endmodule

// File: rtl/scsi_dma_xfer_ctrl.sv
module scsi_dma_xfer_ctrl
  import scsi_xfer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int RES_W   = 24,
  parameter int BUF_W   = 17,
  parameter int CMD_MAX = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    cmd_phase_i,
  input  logic [CNT_W-1:0]        count_i,
  input  logic signed [RES_W-1:0] residual_i,
  input  logic                    abort_i,
  input  logic                    dev_buf_i,
  input  logic [BUF_W-1:0]        dev_len_i,
  input  logic                    dev_done_i,
  output logic                    chunk_req_o,
  output logic [CNT_W:0]          chunk_len_o,
  output logic                    chunk_to_dev_o,
  output logic                    done_o,
  output logic                    busy_o,
  output logic [CNT_W:0]          rem_o,
  output logic signed [RES_W-1:0] residual_o,
  output logic [BUF_W-1:0]        buf_len_o,
  output logic [7:0]              status_o,
  output logic [7:0]              intr_o,
  output logic [2:0]              seq_o,
  output logic [CNT_W-1:0]        count_o,
  output logic                    irq_o
);
  localparam int LW = CNT_W + 1;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  xfer_state_e             state_q, state_d;
  logic [LW-1:0]           rem_q, rem_d;
  logic signed [RES_W-1:0] res_q, res_d;
  logic [BUF_W-1:0]        buf_q, buf_d;
  logic                    dir_q, dir_d;
  logic                    req_q, req_d;
  logic [LW-1:0]           clen_q, clen_d;
  logic                    cdir_q, cdir_d;
  logic                    done_q, done_d;
  logic                    ev_start, ev_finish, ev_devdone;
  logic [2:0]              start_phase;

  logic [LW-1:0]           eff_len;
  logic [LW-1:0]           step_chunk;
  logic [LW-1:0]           step_rem;
  logic [BUF_W-1:0]        step_buf;
  logic signed [RES_W-1:0] step_res;
  logic                    step_fin;
  logic                    res_le_zero;

  xfer_len_calc #(
    .CNT_W  (CNT_W),
    .RES_W  (RES_W),
    .CMD_MAX(CMD_MAX)
  ) u_len (
    .count_i    (count_i),
    .residual_i (residual_i),
    .cmd_phase_i(cmd_phase_i),
    .len_o      (eff_len)
  );

  xfer_chunk_step #(
    .LEN_W(LW),
    .BUF_W(BUF_W),
    .RES_W(RES_W)
  ) u_step (
    .rem_i   (rem_q),
    .buf_i   (buf_q),
    .res_i   (res_q),
    .to_dev_i(dir_q),
    .chunk_o (step_chunk),
    .rem_nx_o(step_rem),
    .buf_nx_o(step_buf),
    .res_nx_o(step_res),
    .finish_o(step_fin)
  );

  assign res_le_zero = res_q[RES_W-1] || (res_q == '0);
  assign start_phase = cmd_phase_i ? PH_COMMAND :
                       (residual_i[RES_W-1] ? PH_DATA_OUT : PH_DATA_IN);

  always_comb begin
    state_d    = state_q;
    rem_d      = rem_q;
    res_d      = res_q;
    buf_d      = buf_q;
    dir_d      = dir_q;
    req_d      = 1'b0;
    clen_d     = '0;
    cdir_d     = 1'b0;
    done_d     = 1'b0;
    ev_start   = 1'b0;
    ev_finish  = 1'b0;
    ev_devdone = 1'b0;
    if (abort_i) begin
      state_d = XS_IDLE;
      rem_d   = '0;
    end else if (dev_done_i) begin
      state_d    = XS_IDLE;
      rem_d      = '0;
      res_d      = '0;
      buf_d      = '0;
      done_d     = 1'b1;
      ev_devdone = 1'b1;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          if (dev_buf_i) buf_d = dev_len_i;
          if (start_i) begin
            ev_start = 1'b1;
            rem_d    = eff_len;
            res_d    = residual_i;
            dir_d    = cmd_phase_i | residual_i[RES_W-1];
            state_d  = cmd_phase_i ? XS_CMD : XS_XFER;
          end
        end
        XS_XFER: begin
          if (buf_q == '0) begin
            state_d = XS_WAIT;
          end else begin
            req_d  = (step_chunk != '0);
            clen_d = step_chunk;
            cdir_d = dir_q;
            rem_d  = step_rem;
            buf_d  = step_buf;
            res_d  = step_res;
            if (step_fin) begin
              done_d    = 1'b1;
              ev_finish = 1'b1;
              state_d   = XS_IDLE;
            end else begin
              state_d = XS_WAIT;
            end
          end
        end
        XS_WAIT: begin
          if (dev_buf_i) begin
            buf_d = dev_len_i;
            if (rem_q != '0) begin
              state_d = XS_XFER;
            end else if (res_le_zero) begin
              done_d    = 1'b1;
              ev_finish = 1'b1;
              state_d   = XS_IDLE;
            end
          end
        end
        XS_CMD: begin
          req_d     = (rem_q != '0);
          clen_d    = rem_q;
          cdir_d    = 1'b1;
          rem_d     = '0;
          res_d     = '0;
          done_d    = 1'b1;
          ev_finish = 1'b1;
          state_d   = XS_IDLE;
        end
        default: state_d = XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= XS_IDLE;
      rem_q   <= '0;
      res_q   <= '0;
      buf_q   <= '0;
      dir_q   <= 1'b0;
      req_q   <= 1'b0;
      clen_q  <= '0;
      cdir_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      res_q   <= res_d;
      buf_q   <= buf_d;
      dir_q   <= dir_d;
      req_q   <= req_d;
      clen_q  <= clen_d;
      cdir_q  <= cdir_d;
      done_q  <= done_d;
    end
  end

  xfer_status_regs #(
    .CNT_W(CNT_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .ev_start_i   (ev_start),
    .start_phase_i(start_phase),
    .start_count_i(count_i),
    .ev_finish_i  (ev_finish),
    .ev_devdone_i (ev_devdone),
    .status_o     (status_o),
    .intr_o       (intr_o),
    .seq_o        (seq_o),
    .count_o      (count_o),
    .irq_o        (irq_o)
  );

  assign chunk_req_o    = req_q;
  assign chunk_len_o    = clen_q;
  assign chunk_to_dev_o = cdir_q;
  assign done_o         = done_q;
  assign busy_o         = (state_q != XS_IDLE);
  assign rem_o          = rem_q;
  assign residual_o     = res_q;
  assign buf_len_o      = buf_q;

endmodule

// File: rtl/scsi_dma_xfer_chk.sv
module scsi_dma_xfer_chk #(
  parameter int CNT_W   = 16,
  parameter int CMD_MAX = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             abort_i,
  input logic             dev_done_i,
  input logic             chunk_req_o,
  input logic [CNT_W:0]   chunk_len_o,
  input logic             done_o,
  input logic             busy_o,
  input logic [CNT_W:0]   rem_o,
  input logic [7:0]       status_o,
  input logic [7:0]       intr_o,
  input logic [2:0]       seq_o,
  input logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W:0] CMD_LIM = (CNT_W+1)'(CMD_MAX);

  AST_DONE_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o[4] && status_o[7] && intr_o == 8'h10 &&
                seq_o == 3'd0 && count_o == '0)); // R10

  AST_CHUNK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_req_o |-> (chunk_len_o != '0)); // R5

  AST_CHUNK_DRAINS_REM: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_req_o && $past(busy_o)) |->
      ($past(rem_o) >= chunk_len_o)); // R5

  AST_CMD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_req_o && status_o[2:0] == 3'd2) |-> (chunk_len_o <= CMD_LIM)); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !abort_i && !dev_done_i) |=>
      (count_o == $past(count_o) || done_o)); // R12

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!done_o && !busy_o)); // R13

  AST_DEVDONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done_i && !abort_i) |=> (status_o[2:0] == 3'd3 && rem_o == '0)); // R11

endmodule

bind scsi_dma_xfer_ctrl scsi_dma_xfer_chk #(
  .CNT_W  (CNT_W),
  .CMD_MAX(CMD_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .abort_i    (abort_i),
  .dev_done_i (dev_done_i),
  .chunk_req_o(chunk_req_o),
  .chunk_len_o(chunk_len_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .rem_o      (rem_o),
  .status_o   (status_o),
  .intr_o     (intr_o),
  .seq_o      (seq_o),
  .count_o    (count_o)
);

// File: tb/scsi_dma_xfer_ctrl_test.sv
module scsi_dma_xfer_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic               start_i = 0, cmd_phase_i = 0, abort_i = 0;
  logic               dev_buf_i = 0, dev_done_i = 0;
  logic [15:0]        count_i = '0;
  logic signed [23:0] residual_i = '0;
  logic [16:0]        dev_len_i = '0;
  logic               chunk_req_o, chunk_to_dev_o, done_o, busy_o, irq_o;
  logic [16:0]        chunk_len_o, rem_o, buf_len_o;
  logic signed [23:0] residual_o;
  logic [7:0]         status_o, intr_o;
  logic [2:0]         seq_o;
  logic [15:0]        count_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  scsi_dma_xfer_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_phase_i(cmd_phase_i),
    .count_i(count_i), .residual_i(residual_i), .abort_i(abort_i),
    .dev_buf_i(dev_buf_i), .dev_len_i(dev_len_i), .dev_done_i(dev_done_i),
    .chunk_req_o(chunk_req_o), .chunk_len_o(chunk_len_o),
    .chunk_to_dev_o(chunk_to_dev_o), .done_o(done_o), .busy_o(busy_o),
    .rem_o(rem_o), .residual_o(residual_o), .buf_len_o(buf_len_o),
    .status_o(status_o), .intr_o(intr_o), .seq_o(seq_o), .count_o(count_o),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_eff(input int cnt, input int res, input bit cmd);
    int len;
    int mag;
    len = (cnt == 0) ? 65536 : cnt;
    if (cmd) return (len < 32) ? len : 32;
    mag = (res < 0) ? -res : res;
    return (len < mag) ? len : mag;
  endfunction

  function automatic int f_min(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic do_start(input int cnt, input int res, input bit cmd);
    @(negedge clk);
    start_i = 1; count_i = 16'(cnt); residual_i = 24'(res); cmd_phase_i = cmd;
    @(negedge clk);
    start_i = 0; cmd_phase_i = 0;
  endtask

  task automatic do_buf(input int len);
    @(negedge clk);
    dev_buf_i = 1; dev_len_i = 17'(len);
    @(negedge clk);
    dev_buf_i = 0;
  endtask

  task automatic do_devdone();
    @(negedge clk);
    dev_done_i = 1;
    @(negedge clk);
    dev_done_i = 0;
  endtask

  task automatic do_abort();
    @(negedge clk);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 status", status_o, 0);
    check("R1 intr", intr_o, 0);
    check("R1 seq", seq_o, 0);
    check("R1 count", count_o, 0);
    check("R1 rem", rem_o, 0);
    check("R1 busy/done/irq/req", {busy_o, done_o, irq_o, chunk_req_o}, 0);

    // from device, partial buffer
    do_buf(100);
    do_start(64, 200, 0);
    check("R2 rem after start", rem_o, 64);
    check("R4 status after start", status_o, 8'h01);
    check("R4 seq after start", seq_o, 4);
    check("R4 count after start", count_o, 64);
    check("R4 busy", busy_o, 1);
    step();
    check("R5 chunk req", chunk_req_o, 1);
    check("R5 chunk len", chunk_len_o, 64);
    check("R5 chunk dir", chunk_to_dev_o, 0);
    check("R5 residual", int'(residual_o), 136);
    check("R5 buffer", buf_len_o, 36);
    check("R7 done on partial buffer", done_o, 1);
    check("R10 status", status_o, 8'h91);
    check("R10 intr", intr_o, 8'h10);
    check("R10 seq/count", {seq_o, count_o}, 0);
    check("R10 irq", irq_o, 1);
    step();
    check("R10 done one cycle", done_o, 0);

    // zero count means 65536
    do_buf(70000);
    do_start(0, 100000, 0);
    check("R2 zero count", rem_o, 65536);
    step();
    check("R2 big chunk", chunk_len_o, 65536);
    check("R7 big done", done_o, 1);

    // command done path
    do_devdone();
    check("R11 done", done_o, 1);
    check("R11 status", status_o, 8'h93);
    check("R11 residual/rem/buf", int'(residual_o) + rem_o + buf_len_o, 0);
    check("R11 idle", busy_o, 0);

    // toward device, empty buffer, multi-step wait
    do_start(20, -50, 0);
    check("R4 phase out", status_o, 8'h00);
    step();
    check("R6 no chunk", chunk_req_o, 0);
    check("R6 still busy", busy_o, 1);
    step();
    check("R6 wait holds", {chunk_req_o, done_o, busy_o}, 1);
    do_buf(20);
    check("R6 not done on event", done_o, 0);
    step();
    check("R5 chunk to dev", {chunk_req_o, chunk_to_dev_o}, 3);
    check("R5 len to dev", chunk_len_o, 20);
    check("R5 res to dev", int'(residual_o), -30);
    check("R8 to dev waits", {done_o, busy_o}, 1);
    do_buf(5);
    check("R9 event completes", done_o, 1);
    check("R9 idle", busy_o, 0);

    // from device, drained, rem zero, residual positive
    do_devdone();
    do_buf(10);
    do_start(10, 40, 0);
    step();
    check("R8 drained from dev done", done_o, 1);
    check("R8 residual", int'(residual_o), 30);

    // from device, drained, rem left
    do_buf(8);
    do_start(20, 40, 0);
    step();
    check("R8 drained rem left waits", {done_o, busy_o}, 1);
    check("R8 rem", rem_o, 12);
    do_buf(12);
    step();
    check("R5 second chunk", chunk_len_o, 12);
    check("R8 second done", done_o, 1);
    check("R8 res", int'(residual_o), 20);

    // command phase
    do_start(100, 77, 1);
    check("R3 rem", rem_o, 32);
    check("R4 phase cmd", status_o[2:0], 2);
    step();
    check("R3 chunk", {chunk_req_o, chunk_to_dev_o}, 3);
    check("R3 len", chunk_len_o, 32);
    check("R3 done", done_o, 1);
    check("R3 residual", int'(residual_o), 0);
    do_start(5, 0, 1);
    step();
    check("R3 short len", chunk_len_o, 5);

    // start while busy, then abort
    do_start(10, -10, 0);
    step();
    do_start(3, 100, 1);
    check("R12 rem kept", rem_o, 10);
    check("R12 count kept", count_o, 10);
    check("R12 status kept", status_o, 8'h00);
    do_abort();
    check("R13 idle", busy_o, 0);
    check("R13 no done", done_o, 0);
    check("R13 status kept", status_o, 8'h00);
    step();
    check("R13 still no done", done_o, 0);

    // constrained random rounds
    for (int it = 0; it < 300; it++) begin
      int b, cnt, res, eff, ch, expd;
      bit todev;
      do_devdone();
      b   = int'($urandom % 300);
      cnt = ($urandom % 8 == 0) ? 0 : int'($urandom % 400);
      res = int'($urandom % 1001) - 500;
      if (b != 0) do_buf(b);
      eff = f_eff(cnt, res, 0);
      todev = (res < 0);
      do_start(cnt, res, 0);
      check("R2 random rem", rem_o, eff);
      check("R4 random phase", status_o, todev ? 0 : 1);
      step();
      if (b == 0) begin
        check("R6 random wait", {chunk_req_o, done_o, busy_o}, 1);
        do_abort();
      end else begin
        ch = f_min(eff, b);
        expd = ((b - ch) != 0) ||
               (!todev && (eff - ch) == 0 && (res - ch) > 0);
        check("R5 random req", chunk_req_o, (ch != 0));
        if (ch != 0) check("R5 random len", chunk_len_o, ch);
        check("R5 random res", int'(residual_o), todev ? res + ch : res - ch);
        check("R7 R8 random done", done_o, expd);
        if (expd) check("R10 random status", status_o, todev ? 8'h90 : 8'h91);
        else do_abort();
      end
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule